// File: doc/BRIEF.md
# PLL Lock Detector with Feedback-Loss Watchdog

This block decides whether a phase-locked loop is locked. It runs on one sampling clock. Two single-cycle event strobes arrive on that clock: one marks a rising edge of the reference, and the other marks a rising edge of the feedback clock. With each feedback strobe comes a signed phase difference, in sampling-clock units, between that feedback edge and its reference edge. A feedback cycle is errored when the magnitude of that difference is larger than an allowed window.

The indication has hysteresis. Acquiring lock takes a long run of clean feedback cycles, and losing it takes a short run of errored ones. A single cycle of the other kind restarts the run.

A watchdog covers a feedback clock that stops altogether. It counts reference edges, divides them down, and drops lock when too many divided periods pass with no feedback edge. The output is asserted when the loop is locked and deasserted while the loop is still acquiring.

Top module: `pll_lock_watch`

## Requirements
- R1: During reset and in the first cycle after it, `lock` is 0, and both run counters start from zero.
- R2: A feedback cycle is errored when |`phase_diff`| > `WINDOW` (default 2), with `phase_diff` read as two's complement. Values of -2..+2 are clean, and -3, +3 and -128 are errored.
- R3: While unlocked, the `lock` output rises after the clock edge that samples the 32nd consecutive clean `fb_tick` (`GAIN_CNT`).
- R4: While unlocked, one errored `fb_tick` restarts the clean run, so 31 more clean cycles after it leave `lock` at 0.
- R5: While locked, the `lock` output falls after the clock edge that samples the 4th consecutive errored `fb_tick` (`LOSE_CNT`).
- R6: While locked, one clean `fb_tick` restarts the error run, so three more errored cycles after it leave `lock` at 1.
- R7: While locked with no `fb_tick`, `lock` falls after the edge that samples the 1024th `ref_tick` since the last feedback edge or since lock was gained (`REF_DIV` 64 × `WD_LIMIT` 16). After 1023 ticks it is still 1.
- R8: An `fb_tick` in the same cycle as the expiring `ref_tick` keeps lock and restarts the full watchdog interval.
- R9: `phase_diff` is ignored in cycles without `fb_tick`, and `lock` changes only on an `fb_tick` or a watchdog expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle strobe per reference rising edge |
| fb_tick | input | 1 | One-cycle strobe per feedback rising edge |
| phase_diff | input | PW (8) | Signed edge difference, valid with `fb_tick` |
| lock | output | 1 | 1 = locked, 0 = acquiring |

## Verification
A feedback edge and the watchdog's final divided reference edge can land in the same cycle. The bench provokes this by stopping feedback after lock and counting reference strobes until 1023 have passed. It then drives the next reference strobe together with a feedback strobe. The expected result is that lock holds and that a further 1023 strobes without feedback still leave it high. A behavioural model counts raw reference strobes, not a divider with a period counter, and is compared with `lock` on every cycle.

// File: rtl/pll_lock_watch.sv
module pll_lock_watch #(
  parameter int PW       = 8,
  parameter int WINDOW   = 2,
  parameter int LOSE_CNT = 4,
  parameter int GAIN_CNT = 32,
  parameter int REF_DIV  = 64,
  parameter int WD_LIMIT = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_tick,
  input  logic          fb_tick,
  input  logic [PW-1:0] phase_diff,
  output logic          lock
);
  localparam int GW = $clog2(GAIN_CNT + 1);
  localparam int BW = $clog2(LOSE_CNT + 1);
  localparam int DW = $clog2(REF_DIV);
  localparam int WW = $clog2(WD_LIMIT + 1);

  logic [GW-1:0] good_cnt;
  logic [BW-1:0] bad_cnt;
  logic [DW-1:0] div_cnt;
  logic [WW-1:0] wd_cnt;
  logic [PW:0]   wide, mag;
  logic          err, div_wrap, wd_expire;

  assign wide      = {phase_diff[PW-1], phase_diff};
  assign mag       = phase_diff[PW-1] ? (~wide + 1'b1) : wide;
  assign err       = mag > (PW+1)'(WINDOW);
  assign div_wrap  = ref_tick && (div_cnt == DW'(REF_DIV - 1));
  assign wd_expire = lock && !fb_tick && div_wrap && (wd_cnt == WW'(WD_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock     <= 1'b0;
      good_cnt <= '0;
      bad_cnt  <= '0;
      div_cnt  <= '0;
      wd_cnt   <= '0;
    end else begin
      if (!lock || fb_tick) begin
        div_cnt <= '0;
        wd_cnt  <= '0;
      end else if (ref_tick) begin
        div_cnt <= div_wrap ? '0 : div_cnt + 1'b1;
        if (div_wrap) wd_cnt <= wd_cnt + 1'b1;
      end

      if (wd_expire) begin
        lock     <= 1'b0;
        good_cnt <= '0;
        bad_cnt  <= '0;
      end else if (fb_tick && !lock) begin
        if (err) good_cnt <= '0;
        else if (good_cnt == GW'(GAIN_CNT - 1)) begin
          lock     <= 1'b1;
          good_cnt <= '0;
          bad_cnt  <= '0;
        end else good_cnt <= good_cnt + 1'b1;
      end else if (fb_tick) begin
        if (!err) bad_cnt <= '0;
        else if (bad_cnt == BW'(LOSE_CNT - 1)) begin
          lock     <= 1'b0;
          good_cnt <= '0;
          bad_cnt  <= '0;
        end else bad_cnt <= bad_cnt + 1'b1;
      end
    end
  end

  AST_RISE_NEEDS_CLEAN_FB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(fb_tick) && $past(good_cnt) == GW'(GAIN_CNT - 1)); // R3
  AST_FALL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock) |-> $past(wd_expire) || ($past(fb_tick) && $past(bad_cnt) == BW'(LOSE_CNT - 1))); // R5
  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !fb_tick && !wd_expire |=> $stable(lock)); // R9
  AST_UNLOCKED_NO_ERRRUN: assert property (@(posedge clk) disable iff (!rst_n)
    !lock |-> bad_cnt == '0); // R6
  AST_CLEAN_RESETS_ERRRUN: assert property (@(posedge clk) disable iff (!rst_n)
    lock && fb_tick && !err |=> bad_cnt == '0); // R6
  AST_WD_FB_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    lock && fb_tick && !err |=> lock && wd_cnt == '0); // R8
endmodule

// File: tb/tb_pll_lock_watch.sv
module tb_pll_lock_watch;
  logic clk = 1'b0, rst_n = 1'b0, ref_tick = 1'b0, fb_tick = 1'b0;
  logic [7:0] phase_diff = '0;
  logic lock;
  int n_chk = 0, n_bad = 0;
  bit done = 0, ref_ph = 0;
  int m_lock = 0, m_good = 0, m_bad = 0, m_since = 0;

  always #5 clk = ~clk;

  pll_lock_watch dut (.clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .fb_tick(fb_tick),
                      .phase_diff(phase_diff), .lock(lock));

  always @(posedge clk) begin
    int d;
    bit e;
    d = $signed(phase_diff);
    e = (d > 2) || (d < -2);
    if (!rst_n) begin
      m_lock = 0; m_good = 0; m_bad = 0; m_since = 0;
    end else if (m_lock == 1 && !fb_tick && ref_tick && m_since + 1 == 1024) begin
      m_lock = 0; m_good = 0; m_bad = 0; m_since = 0;
    end else begin
      if (m_lock == 0 || fb_tick) m_since = 0;
      else if (ref_tick) m_since++;
      if (fb_tick) begin
        if (m_lock == 0) begin
          m_good = e ? 0 : m_good + 1;
          if (m_good == 32) begin m_lock = 1; m_good = 0; m_bad = 0; end
        end else begin
          m_bad = e ? m_bad + 1 : 0;
          if (m_bad == 4) begin m_lock = 0; m_good = 0; m_bad = 0; end
        end
      end
    end
  end

  task automatic check(string tag, int exp);
    n_chk++;
    if (lock !== exp[0]) begin
      n_bad++;
      $display("FAIL %s: lock=%0b expected=%0d", tag, lock, exp);
    end
  endtask

  task automatic step(bit fb, int diff);
    @(negedge clk);
    ref_ph   = ~ref_ph;
    ref_tick = ref_ph;
    fb_tick  = fb;
    phase_diff = 8'(diff);
    @(posedge clk);
    #1;
    check("model R3/R5/R7", m_lock);
  endtask

  task automatic clean(int n);
    for (int i = 0; i < n; i++) step(1, (i % 5) - 2);
  endtask

  task automatic idle_until(int ticks);
    while (!(m_since == ticks && !ref_ph)) step(0, 77);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1 reset", 0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk) #1 check("R1 after reset", 0);
    clean(20);
    step(1, 3);
    clean(31);
    check("R4 errored cycle restarts run", 0);
    clean(1);
    check("R3 lock after 32 clean", 1);
    step(1, -3); step(1, 5); step(1, -128);
    check("R2 three errors keep lock", 1);
    step(1, 2);
    step(1, 3); step(1, -3); step(1, 9);
    check("R6 clean restarts error run", 1);
    step(1, -4);
    check("R5 four errors drop lock", 0);
    for (int i = 0; i < 31; i++) begin
      step(1, -2 + (i % 5));
      step(0, 100);
      step(0, -100);
    end
    check("R9 idle phase ignored", 0);
    step(0, 127);
    step(1, 0);
    check("R9 lock via interleaved clean", 1);
    idle_until(1023);
    check("R7 still locked at 1023", 1);
    step(0, 0);
    check("R7 watchdog drops lock", 0);
    clean(32);
    check("R3 relock", 1);
    idle_until(1023);
    step(1, 1);
    check("R8 fb wins at expiry", 1);
    idle_until(1023);
    check("R8 full interval restarted", 1);
    step(0, 0);
    check("R7 second expiry", 0);
    step(0, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule